// File: doc/BRIEF.md
# Framed Serial-to-Parallel Word Receiver

This block watches a single serial data line, one bit per clock, and turns framed packets into 8-bit parallel words. The line rests at 0. A frame opens with two 1s on consecutive clocks, and 7 data bits follow at once. After each packet, one more bit says what comes next: a 1 means another 7-bit packet follows straight away, and a 0 ends the frame.

For every packet, the block adds a parity bit of the kind chosen by a select input. It loads the 7 data bits and the parity bit into an output register together. One clock later it raises a strobe for a single clock. The output register keeps the word until the next packet loads a new one.

The whole block runs on one clock. An active-low reset clears it asynchronously, and the release of that reset is synchronised to the clock inside the block.

Top module: `sfr_rx_top`

## Requirements
- R1: While the line stays at 0 outside a frame, the strobe stays low and the output word does not change.
- R2: A frame starts only after two 1s on consecutive clocks. The data bit that follows the second 1, on the next clock, is the first data bit of the packet.
- R3: A lone 1 followed by a 0 while idle is discarded. No word is produced, and a later valid frame is decoded as if the lone 1 had never been seen.
- R4: Each packet is 7 bits. The first data bit received lands in output bit 6 and the last in output bit 0.
- R5: Output bit 7 is the parity bit. When the select input is 0, the total number of 1s across all 8 output bits is odd. When it is 1, that total is even.
- R6: The parity type is taken from the select input as it stands during the clock of the seventh data bit. Its value during earlier bits of the packet has no effect.
- R7: After a packet, a 1 continuation bit is followed at once by the first bit of the next packet. A 0 stop bit ends the frame, and another packet needs two new start 1s.
- R8: The output word updates on the clock edge that samples the seventh data bit. The strobe is high for exactly the one clock after that, once per packet.
- R9: The output word holds its value between loads, including across the end of a frame.
- R10: Asserting the reset clears the output word and the strobe at once, and drops any partly received packet. After the reset is released, the block is idle and decodes the next frame normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all data is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; assertion is asynchronous, release is synchronised inside the block |
| ser_in | input | 1 | Serial data line, one bit per clock, 0 when idle |
| par_even | input | 1 | Parity select: 0 for odd parity, 1 for even parity |
| word_out | output | 8 | Received word: parity in bit 7, data bits in 6..0 |
| word_stb | output | 1 | One-clock pulse meaning a new word is on word_out |

## Verification
The assertions assume that the serial line and the parity select change only away from the rising clock edge and stay steady for a whole clock, so every bit is sampled exactly once. They also assume that the reset is held for at least a few clocks. The bench drives every input on the falling edge and holds each value for one full period. It leaves several idle zero clocks after each reset release before it starts a frame. No frame is fed to the block while its internal reset is still held, so the parity and hold properties only ever see words loaded from complete packets.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned PKT_BITS_DEF = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sfr_rst_sync.sv
module sfr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_bit_cnt.sv
module sfr_bit_cnt #(
  parameter int unsigned PKT_BITS = 7,
  localparam int unsigned CNT_W = $clog2(PKT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == CNT_W'(PKT_BITS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_in,
  input  logic      cnt_last,
  output logic      cnt_clr,
  output logic      cnt_en,
  output logic      shift_en,
  output logic      load,
  output rx_state_e state
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    cnt_en   = 1'b0;
    shift_en = 1'b0;
    load     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ser_in) state_d = ST_ONE;
      ST_ONE: begin
        if (ser_in) begin
          state_d = ST_DATA;
          cnt_clr = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_DATA: begin
        cnt_en   = 1'b1;
        shift_en = 1'b1;
        if (cnt_last) begin
          load    = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (ser_in) begin
          state_d = ST_DATA;
          cnt_clr = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath #(
  parameter int unsigned PKT_BITS = 7,
  localparam int unsigned WORD_W = PKT_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              par_even,
  input  logic              shift_en,
  input  logic              load,
  output logic [WORD_W-1:0] word,
  output logic              stb
);
  logic [PKT_BITS-2:0] sh_q, sh_d;
  logic [PKT_BITS-1:0] pkt;
  logic                par_bit;
  logic [WORD_W-1:0]   word_q, word_d;
  logic                ld_q, stb_q;

  assign pkt     = {sh_q, ser_in};
  assign par_bit = (^pkt) ^ ~par_even;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = pkt[PKT_BITS-2:0];
  end

  always_comb begin
    word_d = word_q;
    if (load) word_d = {par_bit, pkt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
      ld_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
      ld_q   <= load;
      stb_q  <= ld_q;
    end
  end

  assign word = word_q;
  assign stb  = stb_q;
endmodule

// File: rtl/sfr_rx_top.sv
module sfr_rx_top
  import sfr_pkg::*;
#(
  parameter int unsigned PKT_BITS = PKT_BITS_DEF,
  localparam int unsigned WORD_W = PKT_BITS + 1,
  localparam int unsigned CNT_W  = $clog2(PKT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              par_even,
  output logic [WORD_W-1:0] word_out,
  output logic              word_stb
);
  logic             rst_n_s;
  logic             cnt_clr, cnt_en, cnt_last, shift_en, load;
  logic [CNT_W-1:0] cnt;
  rx_state_e        state;

  sfr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sfr_bit_cnt #(.PKT_BITS(PKT_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(cnt_clr), .en(cnt_en),
    .cnt(cnt), .last(cnt_last)
  );

  sfr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .ser_in(ser_in), .cnt_last(cnt_last),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .shift_en(shift_en),
    .load(load), .state(state)
  );

  sfr_datapath #(.PKT_BITS(PKT_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n_s), .ser_in(ser_in), .par_even(par_even),
    .shift_en(shift_en), .load(load), .word(word_out), .stb(word_stb)
  );

  // R4: the counter never runs past the packet length while collecting
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_DATA) |-> (cnt < CNT_W'(PKT_BITS)));

  // R8: strobe is a single-clock pulse
  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_stb |=> !word_stb);

  // R9: word already stable when strobed and stays for the next clock
  a_r9_stable_at_stb: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_stb |-> $stable(word_out));
  a_r9_hold_after_stb: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_stb |=> $stable(word_out));

  // R5/R6: total ones parity matches select seen at the seventh data bit
  a_r5_parity_ok: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_stb |-> ((^word_out) == ~$past(par_even, 2)));

  // R1: a settled idle line never carries a strobe
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !word_stb);
endmodule

// File: tb/test_sfr_rx_top.sv
module test_sfr_rx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       par_even = 1'b0;
  logic [7:0] word_out;
  logic       word_stb;

  int n_cmp = 0;
  int n_bad = 0;
  int n_stb = 0;
  int cyc   = 0;
  logic [7:0] expq [64];
  int wr = 0;
  int rd = 0;
  logic stb_prev = 1'b0;

  always #5 clk = ~clk;

  sfr_rx_top i_sfr_rx_top (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .par_even(par_even),
    .word_out(word_out), .word_stb(word_stb)
  );

  // {sel, npk[1:0], pkt0, pkt1, pkt2}
  localparam logic [23:0] VEC [6] = '{
    {1'b0, 2'd1, 7'h55, 7'h00, 7'h00},
    {1'b1, 2'd1, 7'h55, 7'h00, 7'h00},
    {1'b0, 2'd2, 7'h7F, 7'h00, 7'h00},
    {1'b1, 2'd3, 7'h01, 7'h40, 7'h2A},
    {1'b0, 2'd1, 7'h00, 7'h00, 7'h00},
    {1'b1, 2'd2, 7'h7F, 7'h13, 7'h00}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_word(input logic [6:0] pkt, input logic sel);
    int ones = 0;
    for (int k = 0; k < 7; k++) ones += int'(pkt[k]);
    // odd select (0): parity makes total odd; even select (1): total even
    return {(sel ? (ones % 2 == 1) : (ones % 2 == 0)), pkt};
  endfunction

  task automatic drive(input logic b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0);
  endtask

  task automatic send_pkt(input logic [6:0] pkt, input logic sel);
    for (int j = 6; j >= 0; j--) drive(pkt[j]);
    expq[wr] = mk_word(pkt, sel);
    wr++;
  endtask

  task automatic send_frame(input logic [23:0] v);
    logic [6:0] p [3];
    p[0] = v[20:14]; p[1] = v[13:7]; p[2] = v[6:0];
    par_even = v[23];
    drive(1'b1); drive(1'b1);
    for (int i = 0; i < int'(v[22:21]); i++) begin
      if (i > 0) drive(1'b1);
      send_pkt(p[i], v[23]);
    end
    drive(1'b0);
    idle(4);
  endtask

  // word monitor: R4, R5, R7, R8
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_stb) begin
        n_stb++;
        check(!stb_prev, "R8 strobe one clock", 32'(stb_prev), 0);
        check(rd < wr, "R7 unexpected word", 32'(rd), 32'(wr));
        if (rd < wr) begin
          check(word_out == expq[rd], "R4/R5 word", 32'(word_out), 32'(expq[rd]));
          rd++;
        end
      end
      stb_prev = word_stb;
    end else begin
      stb_prev = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int s0;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(word_out == 8'h00, "R10 reset word", 32'(word_out), 0);
    check(word_stb == 1'b0, "R10 reset strobe", 32'(word_stb), 0);
    rst_n = 1'b1;
    idle(5);

    // vector table walk
    for (int v = 0; v < 6; v++) send_frame(VEC[v]);
    check(rd == wr, "R7 all packets strobed", 32'(rd), 32'(wr));

    // R1/R9: long idle keeps word and no strobe
    held = word_out; s0 = n_stb;
    idle(20);
    check(word_out == held, "R9 hold across idle", 32'(word_out), 32'(held));
    check(n_stb == s0, "R1 idle no strobe", 32'(n_stb), 32'(s0));

    // R3: lone 1 then 0, then valid frame
    drive(1'b1); drive(1'b0);
    check(n_stb == s0, "R3 lone one discarded", 32'(n_stb), 32'(s0));
    send_frame({1'b0, 2'd1, 7'h2C, 7'h00, 7'h00});
    check(rd == wr, "R3 frame after lone one", 32'(rd), 32'(wr));

    // R7: single 1s after stop never start a frame
    s0 = n_stb; held = word_out;
    for (int k = 0; k < 10; k++) begin drive(1'b1); drive(1'b0); end
    idle(3);
    check(n_stb == s0, "R7 no start without two ones", 32'(n_stb), 32'(s0));
    check(word_out == held, "R7 word unchanged", 32'(word_out), 32'(held));

    // R2/R8: exact timing of load and strobe
    par_even = 1'b0;
    drive(1'b1); drive(1'b1);
    for (int j = 6; j >= 0; j--) drive(j == 6 ? 1'b1 : 1'b0);
    expq[wr] = mk_word(7'h40, 1'b0); wr++;
    drive(1'b0);
    check(word_out == 8'h40, "R2/R8 word at seventh edge", 32'(word_out), 32'h40);
    check(word_stb == 1'b0, "R8 strobe not yet", 32'(word_stb), 0);
    drive(1'b0);
    check(word_stb == 1'b1, "R8 strobe one clock later", 32'(word_stb), 1);
    drive(1'b0);
    check(word_stb == 1'b0, "R8 strobe drops", 32'(word_stb), 0);
    idle(3);

    // R6: select changes on the seventh bit only
    par_even = 1'b1;
    drive(1'b1); drive(1'b1);
    for (int j = 6; j >= 1; j--) drive(1'b0);
    par_even = 1'b0;
    drive(1'b1);
    expq[wr] = mk_word(7'h01, 1'b0); wr++;
    drive(1'b0);
    check(word_out == 8'h01, "R6 select sampled at last bit", 32'(word_out), 32'h01);
    par_even = 1'b1;
    idle(4);
    check(word_out == 8'h01, "R6 later select has no effect", 32'(word_out), 32'h01);

    // R10: reset in mid packet
    drive(1'b1); drive(1'b1); drive(1'b1); drive(1'b0); drive(1'b1);
    #1 rst_n = 1'b0;
    #1 check(word_out == 8'h00, "R10 async clear word", 32'(word_out), 0);
    check(word_stb == 1'b0, "R10 async clear strobe", 32'(word_stb), 0);
    s0 = n_stb;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    check(n_stb == s0, "R10 partial packet dropped", 32'(n_stb), 32'(s0));
    send_frame({1'b1, 2'd2, 7'h3C, 7'h7E, 7'h00});
    check(rd == wr, "R10 decode after reset", 32'(rd), 32'(wr));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule